// File: doc/BRIEF.md
# Interval-Coded Watchdog Timer

This block is a watchdog countdown controlled through one byte-wide configuration register on a simple register port. The byte packs a two-bit resolution code in its low bits, a five-bit multiplier above it, and a steering bit in the top position. The time-out period, counted in ticks of an external 1/16-second enable, is the multiplier scaled by four raised to the resolution code. Any multiplier of zero leaves the watchdog idle.

Software arms or re-arms the watchdog by writing the configuration register. A read of that same address also services the watchdog: it restarts the countdown from the value already stored. When the countdown runs out, a sticky time-out flag is raised in a separate flags register, which software can read but not write. The steering bit then picks the action. When it is clear, the block emits a one-cycle interrupt pulse. When it is set, the block emits a one-cycle system reset request and wipes the configuration to zero. A neighbouring register that must drop one of its bits on such a time-out takes the reset request pulse as its clear strobe.

Read data is registered and appears on the cycle after the read strobe. Each load is a one-shot: after a time-out the counter stays stopped until the next write or servicing read.

Top module: `wdt_core`

## Requirements
- R1: After reset, interrupt pulse, reset request and time-out flag are 0, and reads of the configuration and flags addresses return 0x00.
- R2: A write to the configuration address (default 0x1FF7) stores the byte, and a later read of that address returns it on the cycle after the read strobe.
- R3: The period in ticks is (1 << (2 * code)) * multiplier, where code is configuration bits [1:0] and multiplier is bits [6:2]. After a load, the time-out fires on exactly that tick and on no earlier one.
- R4: A time-out sets the flag. The flag reads as bit 7 of the flags address (default 0x1FF0), with the other bits 0. A write to the configuration address clears the flag.
- R5: When configuration bit 7 is 0 at time-out, the interrupt pulse is raised, no reset request is raised, and the configuration value is kept.
- R6: When configuration bit 7 is 1 at time-out, the reset request is raised, no interrupt pulse is raised, and the configuration reads 0x00 afterwards.
- R7: A read of the configuration address reloads the countdown with the full period of the stored value.
- R8: Writes to the flags address have no effect on the flag.
- R9: A multiplier of zero never produces a time-out, whatever the resolution code and steering bit.
- R10: After a time-out, no further time-out occurs until the countdown is reloaded by a write or a servicing read.
- R11: The interrupt pulse and the reset request each last exactly one clock cycle, and they are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 13 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data, valid the cycle after bus_rd |
| tick_16hz | input | 1 | One-cycle enable per 1/16 second |
| irq_pulse | output | 1 | One-cycle interrupt on a time-out steered to interrupt |
| reset_req | output | 1 | One-cycle system reset request on a time-out steered to reset |
| timeout_flag | output | 1 | Sticky time-out flag |

## Verification
The assertions assume that tick_16hz is a single-cycle strobe, that the bus strobes are sampled only on clock edges, and that a write and a read aimed at the configuration address in the same cycle resolve in favour of the write. The stimulus drives every strobe for one cycle from the falling edge. It never overlaps a write and a read, and it spaces ticks with random idle gaps. Random configurations keep the longest periods short enough for the run, and random servicing reads fall strictly inside a countdown. Directed cases cover a zero multiplier, writes to the flags address, and the cycles after a time-out.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  typedef enum logic [1:0] {
    FIRE_NONE  = 2'd0,
    FIRE_IRQ   = 2'd1,
    FIRE_RESET = 2'd2
  } fire_e;

  // Choose the time-out action from the expiry strobe and the steering bit.
  function automatic fire_e pick_fire(input logic expire, input logic steer);
    if (!expire)    return FIRE_NONE;
    else if (steer) return FIRE_RESET;
    else            return FIRE_IRQ;
  endfunction

endpackage

// File: rtl/wdt_countdown.sv
module wdt_countdown #(
  parameter int MULT_W = 5,
  parameter int RES_W  = 2,
  parameter int CNT_W  = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [MULT_W-1:0] ld_mult,
  input  logic [RES_W-1:0]  ld_res,
  input  logic              tick,
  output logic              expire
);
  localparam int NRES = 1 << RES_W;

  logic [CNT_W-1:0] scaled [NRES];
  logic [CNT_W-1:0] load_val;
  logic [CNT_W-1:0] cnt;

  // One pre-shifted multiplier per resolution code (factor 4^code).
  for (genvar g = 0; g < NRES; g++) begin : g_scale
    assign scaled[g] = CNT_W'(ld_mult) << (2 * g);
  end

  assign load_val = scaled[ld_res];

  always_ff @(posedge clk) begin
    if (rst)                          cnt <= '0;
    else if (load)                    cnt <= load_val;
    else if (tick && cnt != '0)       cnt <= cnt - CNT_W'(1);
  end

  // The last tick of a running count ends the period; a reload wins.
  assign expire = tick && !load && (cnt == CNT_W'(1));

  // R10: a countdown that has expired stays stopped until reloaded
  p_stop_after_expire_r10: assert property (@(posedge clk) disable iff (rst)
    expire |=> (cnt == '0));

  // R3: a tick moves a running count down by exactly one
  p_step_one_r3: assert property (@(posedge clk) disable iff (rst)
    (tick && !load && cnt != '0) |=> (cnt == $past(cnt) - CNT_W'(1)));

  // R9: an idle counter never signals expiry
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    (cnt == '0) |-> !expire);

endmodule

// File: rtl/wdt_regs.sv
module wdt_regs #(
  parameter int            ADDR_W    = 13,
  parameter int            DATA_W    = 8,
  parameter logic [12:0]   CFG_ADDR  = 13'h1FF7,
  parameter logic [12:0]   FLAG_ADDR = 13'h1FF0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              expire,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] cfg,
  output logic [DATA_W-1:0] load_cfg,
  output logic              load,
  output logic              flag
);
  logic hit_cfg, hit_flag, wr_cfg, rd_cfg;

  assign hit_cfg  = (addr == ADDR_W'(CFG_ADDR));
  assign hit_flag = (addr == ADDR_W'(FLAG_ADDR));
  assign wr_cfg   = wr && hit_cfg;
  assign rd_cfg   = rd && hit_cfg && !wr_cfg;

  // A write reloads from the new byte; a servicing read from the stored one.
  assign load     = wr_cfg || rd_cfg;
  assign load_cfg = wr_cfg ? wdata : cfg;

  always_ff @(posedge clk) begin
    if (rst)                          cfg <= '0;
    else if (wr_cfg)                  cfg <= wdata;
    else if (expire && cfg[DATA_W-1]) cfg <= '0;
  end

  // Flag has no bus write path: only time-out sets it, config write clears it.
  always_ff @(posedge clk) begin
    if (rst)         flag <= 1'b0;
    else if (wr_cfg) flag <= 1'b0;
    else if (expire) flag <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)               rdata <= '0;
    else if (rd && hit_cfg)  rdata <= cfg;
    else if (rd && hit_flag) rdata <= {flag, {(DATA_W-1){1'b0}}};
    else if (rd)             rdata <= '0;
  end

  // R4: writing the configuration leaves the flag clear
  p_write_clears_flag_r4: assert property (@(posedge clk) disable iff (rst)
    (wr && hit_cfg) |=> !flag);

  // R8: a bus write to the flags address never moves the flag
  p_flag_readonly_r8: assert property (@(posedge clk) disable iff (rst)
    (wr && hit_flag && !expire) |=> $stable(flag));

  // R6: a reset-steered time-out wipes the configuration
  p_cfg_wipe_r6: assert property (@(posedge clk) disable iff (rst)
    (expire && cfg[DATA_W-1]) |=> (cfg == '0));

  // R5: an interrupt-steered time-out keeps the configuration
  p_cfg_kept_r5: assert property (@(posedge clk) disable iff (rst)
    (expire && !cfg[DATA_W-1]) |=> $stable(cfg));

endmodule

// File: rtl/wdt_fire.sv
module wdt_fire
  import wdt_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic expire,
  input  logic steer,
  output logic irq_pulse,
  output logic reset_req
);
  fire_e kind;

  assign kind = pick_fire(expire, steer);

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_pulse <= 1'b0;
      reset_req <= 1'b0;
    end else begin
      irq_pulse <= (kind == FIRE_IRQ);
      reset_req <= (kind == FIRE_RESET);
    end
  end

  // R11: each pulse lasts a single cycle and they are exclusive
  p_irq_one_cycle_r11: assert property (@(posedge clk) disable iff (rst)
    irq_pulse |=> !irq_pulse);
  p_rst_one_cycle_r11: assert property (@(posedge clk) disable iff (rst)
    reset_req |=> !reset_req);
  p_exclusive_r11: assert property (@(posedge clk) disable iff (rst)
    !(irq_pulse && reset_req));

endmodule

// File: rtl/wdt_core.sv
module wdt_core #(
  parameter int          ADDR_W    = 13,
  parameter logic [12:0] CFG_ADDR  = 13'h1FF7,
  parameter logic [12:0] FLAG_ADDR = 13'h1FF0,
  parameter int          MULT_W    = 5,
  parameter int          RES_W     = 2,
  localparam int         DATA_W    = MULT_W + RES_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              tick_16hz,
  output logic              irq_pulse,
  output logic              reset_req,
  output logic              timeout_flag
);
  // Widest period: full multiplier shifted by the largest 4^code.
  localparam int CNT_W = MULT_W + 2 * ((1 << RES_W) - 1);

  logic [DATA_W-1:0] cfg, load_cfg;
  logic              load, expire;

  wdt_regs #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .CFG_ADDR (CFG_ADDR),
    .FLAG_ADDR(FLAG_ADDR)
  ) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr      (bus_wr),
    .rd      (bus_rd),
    .addr    (bus_addr),
    .wdata   (bus_wdata),
    .expire  (expire),
    .rdata   (bus_rdata),
    .cfg     (cfg),
    .load_cfg(load_cfg),
    .load    (load),
    .flag    (timeout_flag)
  );

  wdt_countdown #(
    .MULT_W(MULT_W),
    .RES_W (RES_W),
    .CNT_W (CNT_W)
  ) u_count (
    .clk    (clk),
    .rst    (rst),
    .load   (load),
    .ld_mult(load_cfg[RES_W +: MULT_W]),
    .ld_res (load_cfg[RES_W-1:0]),
    .tick   (tick_16hz),
    .expire (expire)
  );

  wdt_fire u_fire (
    .clk      (clk),
    .rst      (rst),
    .expire   (expire),
    .steer    (cfg[DATA_W-1]),
    .irq_pulse(irq_pulse),
    .reset_req(reset_req)
  );

  // R4: whenever an action pulse is out, the flag is already raised
  p_flag_with_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    (irq_pulse || reset_req) |-> timeout_flag);

endmodule

// File: tb/sim_wdt_core.sv
`timescale 1ns/1ps
module sim_wdt_core;
  localparam logic [12:0] CFG_A  = 13'h1FF7;
  localparam logic [12:0] FLAG_A = 13'h1FF0;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0, tick = 1'b0;
  logic [12:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        irq_pulse, reset_req, timeout_flag;

  int n_chk = 0, n_fail = 0;
  int irq_seen = 0, rst_seen = 0;

  always #2.5 clk = ~clk;

  wdt_core u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tick_16hz(tick), .irq_pulse(irq_pulse), .reset_req(reset_req),
    .timeout_flag(timeout_flag)
  );

  always @(negedge clk) if (!rst) begin
    if (irq_pulse) irq_seen++;
    if (reset_req) rst_seen++;
  end

  function automatic int period(input logic [7:0] c);
    return (1 << (2 * c[1:0])) * int'(c[6:2]);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [12:0] a, input logic [7:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0; #1;
  endtask

  task automatic rd(input logic [12:0] a, output logic [7:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; #1; d = bus_rdata;
  endtask

  task automatic do_tick(input int gap);
    repeat (gap) @(negedge clk);
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0; #1;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) do_tick($urandom % 2);
  endtask

  initial begin
    #900000;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int i0, r0;
    void'($urandom(32'h5EED1));
    repeat (4) @(negedge clk);
    rst = 1'b0; #1;

    // R1 reset state
    chk("R1 irq", irq_pulse, 0);
    chk("R1 rst_req", reset_req, 0);
    chk("R1 flag", timeout_flag, 0);
    rd(FLAG_A, d); chk("R1 flags read", d, 8'h00);
    rd(CFG_A, d);  chk("R1 cfg read", d, 8'h00);

    // R2/R3/R5: code 1, mult 1 -> 4 ticks, interrupt steering
    wr(CFG_A, 8'h05);
    rd(FLAG_A, d); chk("R2 flags after write", d, 8'h00);
    i0 = irq_seen; r0 = rst_seen;
    ticks(3);
    chk("R3 no early time-out", irq_seen, i0);
    do_tick(0);
    chk("R5 irq pulse high", irq_pulse, 1);
    chk("R5 no reset req", reset_req, 0);
    chk("R4 flag set", timeout_flag, 1);
    @(negedge clk); #1;
    chk("R11 irq one cycle", irq_pulse, 0);
    // R10: stopped after time-out
    ticks(10);
    chk("R10 no repeat", irq_seen, i0 + 1);
    rd(FLAG_A, d); chk("R4 flags bit7", d, 8'h80);
    // R8: write to flags ignored
    wr(FLAG_A, 8'h00);
    chk("R8 flag kept", timeout_flag, 1);
    rd(FLAG_A, d); chk("R8 flags read", d, 8'h80);
    rd(CFG_A, d); chk("R5 cfg kept", d, 8'h05);
    // R4: config write clears flag; R9: mult 0 never fires
    wr(CFG_A, 8'h83);
    chk("R4 flag cleared", timeout_flag, 0);
    i0 = irq_seen; r0 = rst_seen;
    ticks(300);
    chk("R9 no irq", irq_seen, i0);
    chk("R9 no reset", rst_seen, r0);
    chk("R9 flag clear", timeout_flag, 0);

    // R6: reset steering, 1 tick
    wr(CFG_A, 8'h84);
    do_tick(0);
    chk("R6 reset req high", reset_req, 1);
    chk("R6 no irq", irq_pulse, 0);
    @(negedge clk); #1;
    chk("R11 reset one cycle", reset_req, 0);
    rd(CFG_A, d); chk("R6 cfg wiped", d, 8'h00);

    // R7: servicing read reloads
    wr(CFG_A, 8'h08);
    i0 = irq_seen;
    do_tick(1);
    rd(CFG_A, d); chk("R7 cfg read", d, 8'h08);
    do_tick(0);
    chk("R7 no fire after kick", irq_seen, i0);
    do_tick(2);
    chk("R7 fire after full period", irq_seen, i0 + 1);

    // Random configurations with optional servicing read
    for (int it = 0; it < 24; it++) begin
      logic [7:0] c;
      int n, k;
      logic kick;
      c[1:0] = 2'($urandom % 4);
      c[6:2] = (c[1:0] == 2'd3) ? 5'($urandom % 8 + 1) : 5'($urandom % 31 + 1);
      c[7]   = 1'($urandom % 2);
      n = period(c);
      k = (n > 1) ? int'($urandom % (n - 1)) + 1 : 0;
      kick = (k > 0) && ($urandom % 2 == 1);
      wr(CFG_A, c);
      i0 = irq_seen; r0 = rst_seen;
      if (kick) begin
        ticks(k);
        rd(CFG_A, d); chk("R7 rand cfg", d, c);
      end
      ticks(n - 1);
      chk("R3 rand early irq", irq_seen, i0);
      chk("R3 rand early reset", rst_seen, r0);
      do_tick($urandom % 2);
      chk("R6 rand reset kind", reset_req, c[7]);
      chk("R5 rand irq kind", irq_pulse, !c[7]);
      chk("R4 rand flag", timeout_flag, 1);
      rd(CFG_A, d); chk("R6 rand cfg after", d, c[7] ? 8'h00 : c);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule